// File: doc/BRIEF.md
# Negacyclic Monomial Rotation and Blind-Rotation Sequencer

This block multiplies a stored polynomial of N coefficients by a monomial X^k taken modulo X^N+1. Coefficients are CW-bit two's-complement torus values. A coefficient that wraps past the top index comes back at the bottom with its sign flipped. Because X^N equals −1 in this ring, the exponent is taken in [0, 2N). An exponent of N or above gives a negation together with a rotation by k−N. The rotation is computed in one pass, LANES output coefficients per clock. For output index j the engine reads source index (j−k) mod N and negates the value when the wrap condition holds. A difference option returns X^k·v − v instead of X^k·v. That difference is the operand a controlled multiplexer consumes.

The same engine also drives the accumulator loop of a blind rotation. The loop begins by loading a test polynomial and rotating it by the negated rounded body value. For each mask index it then does the following:
- fetches the mask value over a request/response pair and rounds it to the 2N grid;
- forms X^ã·ACC − ACC;
- hands that vector to an external-product unit outside this block;
- adds the returned vector back onto the accumulator.

When the last iteration has been absorbed, the final accumulator appears on the output vector and a done pulse marks it.

Top module: `negacyc_rot_unit`

## Requirements
- R1: In rotate mode (op_blind=0, diff_en=0) with 0 ≤ k < N, output coefficient j equals input coefficient (j−k) mod N. It is negated modulo 2^CW exactly when j < k. Coefficient j occupies bits [j*CW +: CW] of every vector port.
- R2: For N ≤ k < 2N the result equals the negation of the rotation by k−N. In particular k = N returns every coefficient negated.
- R3: With diff_en=1 in rotate mode, each output coefficient equals the rotated coefficient minus input coefficient j, modulo 2^CW.
- R4: done is a one-cycle pulse during which busy is low. busy is high from the edge that accepts start until done. A rotate result with its done pulse is visible N/LANES clock edges after the accepting edge.
- R5: Body and mask values are rounded as r = ((t + 2^(CW−L−1)) mod 2^CW) >> (CW−L), with L = log2(2N). Exact halfway values round up, and the result wraps modulo 2N.
- R6: A blind rotation (op_blind=1) starts the accumulator at X^((2N − r_body) mod 2N) times the vector on vec_in.
- R7: Iteration i raises mask_req with mask_idx = i, for i = 0 to NMASK−1 in order. mask_req holds until mask_valid. Iteration i then presents ep_req_vec = X^ã_i·ACC − ACC, where ã_i is the rounded mask value.
- R8: ep_req_valid and ep_req_idx hold until ep_req_ready. mask_req and ep_req_valid are never high together. Each iteration issues exactly one request, and the block waits for ep_rsp_valid before moving on.
- R9: On ep_rsp_valid the accumulator becomes ACC + ep_rsp_vec. After iteration NMASK−1, done pulses with vec_out equal to the final accumulator.
- R10: start is ignored while busy. The running operation finishes with its original operands and timing.
- R11: While rst_n is low at a clock edge, busy, done, mask_req and ep_req_valid go low and vec_out is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| op_blind | input | 1 | 0 = single rotation, 1 = blind-rotation loop |
| diff_en | input | 1 | Rotate mode: output X^k·v − v |
| k_in | input | L | Rotation exponent in [0, 2N) |
| vec_in | input | N*CW | Source vector or test polynomial |
| body_in | input | CW | Torus body value for the loop start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid pulse |
| vec_out | output | N*CW | Result vector |
| mask_req | output | 1 | Requests mask value mask_idx |
| mask_idx | output | IW | Current iteration index |
| mask_valid | input | 1 | mask_in is valid |
| mask_in | input | CW | Torus mask value |
| ep_req_valid | output | 1 | External-product request valid |
| ep_req_ready | input | 1 | Request accepted |
| ep_req_idx | output | IW | Iteration of the request |
| ep_req_vec | output | N*CW | Difference vector X^ã·ACC − ACC |
| ep_rsp_valid | input | 1 | Response valid |
| ep_rsp_vec | input | N*CW | External-product result |

## Verification
The bench builds the unit with N = 16, four lanes, 32-bit coefficients and six loop iterations. At that size every exponent in [0, 32) fits a short run, including the k = 0, k = N and k = 2N−1 boundaries. A four-beat pass means the latency and a mid-operation start can both be observed. Six iterations take a complete blind rotation to its end in a few hundred cycles. The bench stands in for the external product with a selector bit per iteration that returns either the difference or zero, which turns each iteration into a conditional rotation a reference model can follow. Mask and body values placed on and beside rounding halfway points exercise the grid rounding.

// File: rtl/nc_pkg.sv
// Shared types for the negacyclic rotation unit.
// Assumes: nothing beyond the state list below.
package nc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,   // waiting for start
        ST_ROT,    // single rotation beats
        ST_INIT,   // rotating test polynomial by -body
        ST_CPY,    // result -> accumulator
        ST_MASK,   // fetching mask value
        ST_DIFF,   // forming X^a*ACC - ACC
        ST_REQ,    // external-product request pending
        ST_WAIT,   // awaiting external-product response
        ST_FIN     // accumulator -> output
    } nc_state_e;

endpackage

// File: rtl/nc_torus_round.sv
// Rounds a torus value to the 2N grid: nearest integer of t*2N/2^CW,
// halfway rounding up, result modulo 2N.
// Assumes: CW > L so at least one fractional bit exists.
module nc_torus_round #(
    parameter int CW = 32,
    parameter int L  = 7
) (
    input  logic [CW-1:0] t,
    output logic [L-1:0]  r
);
    localparam int SH = CW - L;

    logic [CW-1:0] sum;

    // Add half a grid step (wrapping) and keep the top L bits.
    always_comb begin
        sum = t + CW'(1 << (SH - 1));
        r   = L'(sum >> SH);
    end
endmodule

// File: rtl/nc_lane_rotator.sv
// Computes LANES coefficients of X^k * src (mod X^N + 1) for output
// indices beat*LANES + g, optionally minus src itself.
// Assumes: N and LANES are powers of two, k in [0, 2N).
module nc_lane_rotator #(
    parameter int N     = 64,
    parameter int CW    = 32,
    parameter int LANES = 4,
    localparam int L    = $clog2(2 * N),
    localparam int LOGN = L - 1,
    localparam int BW   = $clog2(N / LANES)
) (
    input  logic [N*CW-1:0]     src_vec,
    input  logic [BW-1:0]       beat,
    input  logic [L-1:0]        k,
    input  logic                diff_en,
    output logic [LANES*CW-1:0] lanes_out
);
    logic [LOGN-1:0] shift;
    logic            half;

    // Split the exponent into in-ring shift and the X^N sign.
    always_comb begin
        shift = k[LOGN-1:0];
        half  = k[L-1];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LOGN-1:0] j;
        logic [LOGN-1:0] src_i;
        logic            neg;
        logic [CW-1:0]   v;
        logic [CW-1:0]   rot;

        // Locate the source coefficient and its sign for lane g.
        always_comb begin
            j     = LOGN'(int'(beat) * LANES + g);
            src_i = j - shift;
            neg   = (j < shift) ^ half;
            v     = src_vec[int'(src_i)*CW +: CW];
            rot   = neg ? (CW'(0) - v) : v;
        end

        assign lanes_out[g*CW +: CW] =
            diff_en ? (rot - src_vec[int'(j)*CW +: CW]) : rot;
    end
endmodule

// File: rtl/nc_blind_seq.sv
// Control for the rotation unit: runs single rotations and the
// blind-rotation loop (init rotation, then per iteration: mask fetch,
// difference pass, external-product request, accumulate).
// Assumes: NMASK >= 2, N/LANES >= 2, start sampled only in idle.
module nc_blind_seq
    import nc_pkg::*;
#(
    parameter int N     = 64,
    parameter int LANES = 4,
    parameter int NMASK = 630,
    localparam int L    = $clog2(2 * N),
    localparam int NB   = N / LANES,
    localparam int BW   = $clog2(NB),
    localparam int IW   = $clog2(NMASK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_blind,
    input  logic          diff_en,
    input  logic [L-1:0]  k_in,
    input  logic [L-1:0]  body_r,
    input  logic          mask_valid,
    input  logic [L-1:0]  mask_r,
    input  logic          ep_req_ready,
    input  logic          ep_rsp_valid,
    output logic          ld_in,
    output logic          eng_wr,
    output logic [BW-1:0] beat,
    output logic [L-1:0]  k_cur,
    output logic          diff_cur,
    output logic          cpy_acc,
    output logic          acc_add,
    output logic          fin_cpy,
    output logic          mask_req,
    output logic [IW-1:0] iter,
    output logic          ep_req_valid,
    output logic          busy,
    output logic          done
);
    nc_state_e     state_q;
    logic [BW-1:0] beat_q;
    logic [IW-1:0] iter_q;
    logic [L-1:0]  k_q;
    logic          diff_q;
    logic          done_q;
    logic          last_beat;
    logic          last_iter;

    // Terminal counts for beats and iterations.
    always_comb begin
        last_beat = (beat_q == BW'(NB - 1));
        last_iter = (iter_q == IW'(NMASK - 1));
    end

    // State, counters and operand registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            iter_q  <= '0;
            k_q     <= '0;
            diff_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        k_q     <= op_blind ? (L'(0) - body_r) : k_in;
                        diff_q  <= op_blind ? 1'b0 : diff_en;
                        beat_q  <= '0;
                        iter_q  <= '0;
                        state_q <= op_blind ? ST_INIT : ST_ROT;
                    end
                end
                ST_ROT, ST_INIT, ST_DIFF: begin
                    beat_q <= beat_q + 1'b1;
                    if (last_beat) begin
                        beat_q <= '0;
                        if (state_q == ST_ROT) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else if (state_q == ST_INIT) begin
                            state_q <= ST_CPY;
                        end else begin
                            state_q <= ST_REQ;
                        end
                    end
                end
                ST_CPY: state_q <= ST_MASK;
                ST_MASK: begin
                    if (mask_valid) begin
                        k_q     <= mask_r;
                        diff_q  <= 1'b1;
                        beat_q  <= '0;
                        state_q <= ST_DIFF;
                    end
                end
                ST_REQ: begin
                    if (ep_req_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (ep_rsp_valid) begin
                        if (last_iter) begin
                            state_q <= ST_FIN;
                        end else begin
                            iter_q  <= iter_q + 1'b1;
                            state_q <= ST_MASK;
                        end
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode datapath strobes and handshake outputs from the state.
    always_comb begin
        ld_in        = (state_q == ST_IDLE) && start;
        eng_wr       = (state_q == ST_ROT) || (state_q == ST_INIT) ||
                       (state_q == ST_DIFF);
        cpy_acc      = (state_q == ST_CPY);
        acc_add      = (state_q == ST_WAIT) && ep_rsp_valid;
        fin_cpy      = (state_q == ST_FIN);
        mask_req     = (state_q == ST_MASK);
        ep_req_valid = (state_q == ST_REQ);
        busy         = (state_q != ST_IDLE);
        beat         = beat_q;
        iter         = iter_q;
        k_cur        = k_q;
        diff_cur     = diff_q;
        done         = done_q;
    end
endmodule

// File: rtl/negacyc_rot_unit.sv
// Negacyclic monomial rotation unit with blind-rotation sequencing.
// Holds the accumulator and result vectors; the result vector doubles
// as the external-product request buffer and the output.
// Assumes: N, LANES powers of two; N/LANES >= 2; NMASK >= 2; CW > log2(2N).
module negacyc_rot_unit #(
    parameter int N     = 64,
    parameter int LANES = 4,
    parameter int CW    = 32,
    parameter int NMASK = 630,
    localparam int L    = $clog2(2 * N),
    localparam int BW   = $clog2(N / LANES),
    localparam int IW   = $clog2(NMASK)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            op_blind,
    input  logic            diff_en,
    input  logic [L-1:0]    k_in,
    input  logic [N*CW-1:0] vec_in,
    input  logic [CW-1:0]   body_in,
    output logic            busy,
    output logic            done,
    output logic [N*CW-1:0] vec_out,
    output logic            mask_req,
    output logic [IW-1:0]   mask_idx,
    input  logic            mask_valid,
    input  logic [CW-1:0]   mask_in,
    output logic            ep_req_valid,
    input  logic            ep_req_ready,
    output logic [IW-1:0]   ep_req_idx,
    output logic [N*CW-1:0] ep_req_vec,
    input  logic            ep_rsp_valid,
    input  logic [N*CW-1:0] ep_rsp_vec
);
    logic [N*CW-1:0]     acc_q;
    logic [N*CW-1:0]     res_q;
    logic [LANES*CW-1:0] lanes;
    logic [L-1:0]        body_r;
    logic [L-1:0]        mask_r;
    logic                ld_in;
    logic                eng_wr;
    logic [BW-1:0]       beat;
    logic [L-1:0]        k_cur;
    logic                diff_cur;
    logic                cpy_acc;
    logic                acc_add;
    logic                fin_cpy;
    logic [IW-1:0]       iter;

    nc_torus_round #(.CW(CW), .L(L)) u_rnd_body (.t(body_in), .r(body_r));
    nc_torus_round #(.CW(CW), .L(L)) u_rnd_mask (.t(mask_in), .r(mask_r));

    nc_blind_seq #(.N(N), .LANES(LANES), .NMASK(NMASK)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .op_blind     (op_blind),
        .diff_en      (diff_en),
        .k_in         (k_in),
        .body_r       (body_r),
        .mask_valid   (mask_valid),
        .mask_r       (mask_r),
        .ep_req_ready (ep_req_ready),
        .ep_rsp_valid (ep_rsp_valid),
        .ld_in        (ld_in),
        .eng_wr       (eng_wr),
        .beat         (beat),
        .k_cur        (k_cur),
        .diff_cur     (diff_cur),
        .cpy_acc      (cpy_acc),
        .acc_add      (acc_add),
        .fin_cpy      (fin_cpy),
        .mask_req     (mask_req),
        .iter         (iter),
        .ep_req_valid (ep_req_valid),
        .busy         (busy),
        .done         (done)
    );

    nc_lane_rotator #(.N(N), .CW(CW), .LANES(LANES)) u_rot (
        .src_vec   (acc_q),
        .beat      (beat),
        .k         (k_cur),
        .diff_en   (diff_cur),
        .lanes_out (lanes)
    );

    // Accumulator: load source, take init result, or add response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (ld_in) begin
            acc_q <= vec_in;
        end else if (cpy_acc) begin
            acc_q <= res_q;
        end else if (acc_add) begin
            for (int j = 0; j < N; j++) begin
                acc_q[j*CW +: CW] <= acc_q[j*CW +: CW] + ep_rsp_vec[j*CW +: CW];
            end
        end
    end

    // Result buffer: lane writes per beat, final accumulator copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (eng_wr) begin
            for (int g = 0; g < LANES; g++) begin
                res_q[(int'(beat)*LANES + g)*CW +: CW] <= lanes[g*CW +: CW];
            end
        end else if (fin_cpy) begin
            res_q <= acc_q;
        end
    end

    assign vec_out    = res_q;
    assign ep_req_vec = res_q;
    assign mask_idx   = iter;
    assign ep_req_idx = iter;
endmodule

// File: rtl/nc_rot_checker.sv
// Protocol checks for negacyc_rot_unit, attached by bind below.
// Assumes: synchronous active-low reset on rst_n.
module nc_rot_checker #(
    parameter int IW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          mask_req,
    input logic [IW-1:0] mask_idx,
    input logic          mask_valid,
    input logic          ep_req_valid,
    input logic          ep_req_ready,
    input logic [IW-1:0] ep_req_idx
);
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_req && !mask_valid) |=> (mask_req && $stable(mask_idx)));

    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_req_valid && !ep_req_ready) |=> (ep_req_valid && $stable(ep_req_idx)));

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mask_req && ep_req_valid));

    a_r8_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_req_valid || mask_req) |-> busy);
endmodule

bind negacyc_rot_unit nc_rot_checker #(.IW(IW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .mask_req     (mask_req),
    .mask_idx     (mask_idx),
    .mask_valid   (mask_valid),
    .ep_req_valid (ep_req_valid),
    .ep_req_ready (ep_req_ready),
    .ep_req_idx   (ep_req_idx)
);

// File: tb/sim_negacyc_rot_unit.sv
`timescale 1ns/1ps
// Self-checking bench: rotations against a step-by-step multiply-by-X
// model, and blind-rotation loops against a conditional-rotation model.
module sim_negacyc_rot_unit;
    localparam int N  = 16;
    localparam int LN = 4;
    localparam int CW = 32;
    localparam int NM = 6;
    localparam int L  = 5;
    localparam int IW = 3;
    localparam int NB = N / LN;

    typedef logic [N*CW-1:0] vec_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op_blind = 1'b0;
    logic          diff_en = 1'b0;
    logic [L-1:0]  k_in = '0;
    vec_t          vec_in = '0;
    logic [CW-1:0] body_in = '0;
    logic          busy, done, mask_req, ep_req_valid;
    vec_t          vec_out, ep_req_vec;
    logic [IW-1:0] mask_idx, ep_req_idx;
    logic          mask_valid = 1'b0;
    logic [CW-1:0] mask_in = '0;
    logic          ep_req_ready = 1'b0;
    logic          ep_rsp_valid = 1'b0;
    vec_t          ep_rsp_vec = '0;

    int n_tests = 0;
    int n_fail  = 0;

    logic [CW-1:0] br_mask [NM];
    logic [NM-1:0] br_key;

    always #10 clk = ~clk;

    negacyc_rot_unit #(.N(N), .LANES(LN), .CW(CW), .NMASK(NM)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_blind(op_blind),
        .diff_en(diff_en), .k_in(k_in), .vec_in(vec_in), .body_in(body_in),
        .busy(busy), .done(done), .vec_out(vec_out), .mask_req(mask_req),
        .mask_idx(mask_idx), .mask_valid(mask_valid), .mask_in(mask_in),
        .ep_req_valid(ep_req_valid), .ep_req_ready(ep_req_ready),
        .ep_req_idx(ep_req_idx), .ep_req_vec(ep_req_vec),
        .ep_rsp_valid(ep_rsp_valid), .ep_rsp_vec(ep_rsp_vec)
    );

    function automatic vec_t mulx(vec_t v);
        vec_t o;
        o[0 +: CW] = CW'(0) - v[(N-1)*CW +: CW];
        for (int j = 1; j < N; j++) o[j*CW +: CW] = v[(j-1)*CW +: CW];
        return o;
    endfunction

    function automatic vec_t rotk(vec_t v, int k);
        vec_t o = v;
        for (int i = 0; i < k; i++) o = mulx(o);
        return o;
    endfunction

    function automatic vec_t vsub(vec_t a, vec_t b);
        vec_t o;
        for (int j = 0; j < N; j++) o[j*CW +: CW] = a[j*CW +: CW] - b[j*CW +: CW];
        return o;
    endfunction

    function automatic vec_t vadd(vec_t a, vec_t b);
        vec_t o;
        for (int j = 0; j < N; j++) o[j*CW +: CW] = a[j*CW +: CW] + b[j*CW +: CW];
        return o;
    endfunction

    function automatic int rnd(logic [CW-1:0] t);
        logic [CW-1:0] s = t + CW'(1 << (CW - L - 1));
        return int'(s >> (CW - L));
    endfunction

    function automatic vec_t rand_vec();
        vec_t o;
        for (int j = 0; j < N; j++) o[j*CW +: CW] = $urandom;
        return o;
    endfunction

    task automatic chk_vec(string req, vec_t act, vec_t exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_int(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One standalone rotation; optionally pokes start while busy (R10).
    task automatic run_rot(vec_t v, int k, bit dif, bit poke, string req);
        vec_t exp = dif ? vsub(rotk(v, k), v) : rotk(v, k);
        int   cnt = 0;
        @(negedge clk);
        start = 1'b1; op_blind = 1'b0; diff_en = dif; k_in = L'(k); vec_in = v;
        @(posedge clk);
        forever begin
            @(negedge clk);
            start = 1'b0;
            if (cnt == 1) chk_int({req, " R4 busy during pass"}, int'(busy), 1);
            if (poke && cnt == 1) begin
                start = 1'b1; op_blind = 1'b1; vec_in = ~v; k_in = L'(k + 3);
            end
            if (done || cnt > 100) break;
            @(posedge clk);
            cnt++;
        end
        chk_vec(req, vec_out, exp);
        chk_int({req, " R4 latency"}, cnt, NB);
        chk_int({req, " R4 busy low at done"}, int'(busy), 0);
    endtask

    // One blind rotation; the bench acts as mask source and a CMUX stand-in
    // returning the difference when br_key[i] is set and zero otherwise.
    task automatic run_br(vec_t tv, logic [CW-1:0] body, string req);
        vec_t model = rotk(tv, (2*N - rnd(body)) % (2*N));
        vec_t dexp = '0;
        int   ei = 0;
        int   guard = 0;
        bit   acc_pend = 1'b0;
        bit   seen = 1'b0;
        @(negedge clk);
        start = 1'b1; op_blind = 1'b1; vec_in = tv; body_in = body;
        @(posedge clk);
        forever begin
            @(negedge clk);
            start = 1'b0; mask_valid = 1'b0; ep_req_ready = 1'b0; ep_rsp_valid = 1'b0;
            guard++;
            if (done || guard > 3000) break;
            if (mask_req && ($urandom % 2 == 0)) begin
                chk_int({req, " R7 mask index"}, int'(mask_idx), ei);
                mask_valid = 1'b1;
                mask_in = br_mask[ei % NM];
            end
            if (ep_req_valid && !acc_pend) begin
                if (!seen) begin
                    dexp = vsub(rotk(model, rnd(br_mask[ei % NM])), model);
                    chk_vec({req, " R7 difference request"}, ep_req_vec, dexp);
                    chk_int({req, " R8 request index"}, int'(ep_req_idx), ei);
                    seen = 1'b1;
                end
                if ($urandom % 2 == 0) begin
                    ep_req_ready = 1'b1;
                    acc_pend = 1'b1;
                end
            end else if (acc_pend && ($urandom % 3 == 0)) begin
                ep_rsp_valid = 1'b1;
                ep_rsp_vec = br_key[ei % NM] ? dexp : '0;
                model = vadd(model, ep_rsp_vec);
                ei++; acc_pend = 1'b0; seen = 1'b0;
            end
        end
        chk_int({req, " R8 one request per iteration"}, ei, NM);
        chk_vec({req, " R9 final accumulator"}, vec_out, model);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        vec_t v;
        void'($urandom(32'd20251));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk_int("R11 busy", int'(busy), 0);
        chk_int("R11 done", int'(done), 0);
        chk_int("R11 mask_req", int'(mask_req), 0);
        chk_int("R11 ep_req_valid", int'(ep_req_valid), 0);
        chk_vec("R11 vec_out", vec_out, '0);

        // Directed corners: R1 k=0, R2 k=N and k=2N-1, R3 difference.
        v = rand_vec();
        run_rot(v, 0, 1'b0, 1'b0, "R1 k=0");
        run_rot(v, 1, 1'b0, 1'b0, "R1 k=1");
        run_rot(v, N - 1, 1'b0, 1'b0, "R1 k=N-1");
        run_rot(v, N, 1'b0, 1'b0, "R2 k=N");
        run_rot(v, 2*N - 1, 1'b0, 1'b0, "R2 k=2N-1");
        run_rot(v, 5, 1'b1, 1'b0, "R3 diff k=5");
        run_rot(v, N + 2, 1'b1, 1'b0, "R3 diff k=N+2");
        run_rot(rand_vec(), 7, 1'b0, 1'b1, "R10 start while busy");

        // Random rotations covering both halves of the exponent range.
        for (int i = 0; i < 16; i++) begin
            int  k = $urandom % (2*N);
            bit  d = 1'(($urandom % 2));
            run_rot(rand_vec(), k, d, 1'b0, (k < N) ? "R1 random" : "R2 random");
        end

        // R6: all selectors zero, so the result is the init rotation alone.
        for (int i = 0; i < NM; i++) br_mask[i] = $urandom;
        br_key = '0;
        run_br(rand_vec(), 32'h3000_0000, "R6 init only");

        // R5: body and masks on and beside halfway points.
        br_key = '1;
        br_mask[0] = 32'h0400_0000;
        br_mask[1] = 32'h03FF_FFFF;
        br_mask[2] = 32'hFFFF_FFFF;
        br_mask[3] = 32'h7C00_0000;
        br_mask[4] = 32'h0000_0000;
        br_mask[5] = 32'hFC00_0000;
        run_br(rand_vec(), 32'h0C00_0000, "R5 rounding");

        // R7/R9: random masks and selectors.
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < NM; i++) br_mask[i] = $urandom;
            br_key = NM'($urandom);
            run_br(rand_vec(), $urandom, "R7 random loop");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule